// File: doc/BRIEF.md
# Tile Integer Vector ALU with Broadcast Reductions

This block is the integer datapath of a vector unit that works on whole tiles. A tile is a ROWS x COLS grid of signed W-bit lanes, 4 x 4 x 32 bits by default. Each request carries an operation code and two source tiles, A and B. The block applies the operation lane by lane, or reduces along rows, along columns or over the whole tile. The result tile comes back one cycle after the request is accepted.

Lanes are packed flat. The lane at row r and column c sits at bits `[(r*COLS+c)*W +: W]`. The result register doubles as the output register and holds the most recent result. A masked-select operation reads that register, so a sequence of selects can merge several tiles lane by lane. Requests and results each use a valid/ready handshake. Only one result is in flight at a time.

Top module: `tile_valu`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the stored result tile is all zeros. A SELECT (code 17) with an all-zero A tile as the first request returns zeros.
- R2: A request is taken in a cycle where `in_valid` and `in_ready` are both 1. `out_valid` is 1 in the next cycle. While `out_valid` is 1, `in_ready` is 0 and `out_data` holds its value. Both continue until a cycle with `out_ready` high ends the result.
- R3: Codes ADD=0, SUB=1 and MUL=2 wrap modulo 2^W. DIV=3 is signed and truncates toward zero. A zero divisor gives 0, and the most negative value divided by -1 gives the most negative value.
- R4: Codes MAX=4 and MIN=5 compare as signed values. AND=8, OR=9 and XOR=10 are bitwise. NOT=15 inverts A, and COPY=16 passes A through.
- R5: SHL=6 and SHR=7 shift A by B's low log2(W) bits (5 bits at W=32), and the higher bits of B are ignored. SHR is arithmetic.
- R6: The comparisons LT=11 (signed A<B), NE=12 and EQ=13 return 1 when true and 0 when false.
- R7: RELU=14 returns A when A is positive and 0 otherwise.
- R8: SELECT=17 returns the B lane where the A lane is nonzero. Otherwise it returns that lane of the previous result. Every accepted request, whatever its code, replaces the stored result.
- R9: Codes 18..21 (sum, max, min, product) combine the COLS lanes of each row of A. Each writes its value into every lane of that row.
- R10: Codes 22..25 (sum, max, min, product) combine the ROWS lanes of each column of A. Each writes its value into every lane of that column.
- R11: Codes 26..29 (sum, max, min, product) combine all lanes of A and write the scalar into every lane. Sums and products wrap modulo 2^W.
- R12: Codes 30 and 31 return an all-zero tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 5 | Operation code |
| in_a | input | ROWS*COLS*W | Source tile A (also the mask for SELECT) |
| in_b | input | ROWS*COLS*W | Source tile B |
| out_valid | output | 1 | Result tile present |
| out_ready | input | 1 | Result taken |
| out_data | output | ROWS*COLS*W | Result tile |

## Verification
The bench builds the block with its defaults: 4 x 4 lanes of 32 bits. At that width the 5-bit shift field, the wrap of the most negative value under division and negation, and signed 32-bit overflow in products all match plain `int` arithmetic. A reference model written with `int` arithmetic can therefore predict every lane exactly. Rectangular or narrower builds follow the same parameters, but the bench does not instantiate them. With only sixteen lanes, a corner-value tile places zero divisors, -1 divisors, shift amounts above 31 and wrapping products in a single request.

// File: rtl/tile_valu_pkg.sv
package tile_valu_pkg;
   localparam int OP_W = 5;

   localparam logic [OP_W-1:0] OP_ADD   = 5'd0;
   localparam logic [OP_W-1:0] OP_SUB   = 5'd1;
   localparam logic [OP_W-1:0] OP_MUL   = 5'd2;
   localparam logic [OP_W-1:0] OP_DIV   = 5'd3;
   localparam logic [OP_W-1:0] OP_MAX   = 5'd4;
   localparam logic [OP_W-1:0] OP_MIN   = 5'd5;
   localparam logic [OP_W-1:0] OP_SHL   = 5'd6;
   localparam logic [OP_W-1:0] OP_SHR   = 5'd7;
   localparam logic [OP_W-1:0] OP_AND   = 5'd8;
   localparam logic [OP_W-1:0] OP_OR    = 5'd9;
   localparam logic [OP_W-1:0] OP_XOR   = 5'd10;
   localparam logic [OP_W-1:0] OP_LT    = 5'd11;
   localparam logic [OP_W-1:0] OP_NE    = 5'd12;
   localparam logic [OP_W-1:0] OP_EQ    = 5'd13;
   localparam logic [OP_W-1:0] OP_RELU  = 5'd14;
   localparam logic [OP_W-1:0] OP_NOT   = 5'd15;
   localparam logic [OP_W-1:0] OP_COPY  = 5'd16;
   localparam logic [OP_W-1:0] OP_SEL   = 5'd17;
   localparam logic [OP_W-1:0] OP_ROW0  = 5'd18;
   localparam logic [OP_W-1:0] OP_COL0  = 5'd22;
   localparam logic [OP_W-1:0] OP_TILE0 = 5'd26;
   localparam logic [OP_W-1:0] OP_LAST  = 5'd29;

   // reduction combiner selected by the low two bits of (op - first op of group)
   typedef enum logic [1:0] {
      RK_SUM  = 2'd0,
      RK_MAX  = 2'd1,
      RK_MIN  = 2'd2,
      RK_PROD = 2'd3
   } red_kind_e;

   typedef enum logic [1:0] {
      GRP_LANE = 2'd0,
      GRP_ROW  = 2'd1,
      GRP_COL  = 2'd2,
      GRP_TILE = 2'd3
   } op_group_e;
endpackage

// File: rtl/valu_lane.sv
module valu_lane
   import tile_valu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  logic [W-1:0]    prev,
   output logic [W-1:0]    y
);
   localparam int SH_W = $clog2(W);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

   logic signed [W-1:0] sa, sb;
   logic [SH_W-1:0]     amt;
   logic [W-1:0]        quo;
   logic                lt_s;

   assign sa   = a;
   assign sb   = b;
   assign amt  = b[SH_W-1:0];
   assign lt_s = (sa < sb);

   always_comb begin
      if (b == '0)
         quo = '0;
      else if (a == MOST_NEG && b == '1)
         quo = MOST_NEG;
      else
         quo = $unsigned(sa / sb);
   end

   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_MUL:  y = a * b;
         OP_DIV:  y = quo;
         OP_MAX:  y = lt_s ? b : a;
         OP_MIN:  y = lt_s ? a : b;
         OP_SHL:  y = a << amt;
         OP_SHR:  y = $unsigned(sa >>> amt);
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_LT:   y = lt_s ? ONE : '0;
         OP_NE:   y = (a != b) ? ONE : '0;
         OP_EQ:   y = (a == b) ? ONE : '0;
         OP_RELU: y = sa[W-1] ? '0 : a;
         OP_NOT:  y = ~a;
         OP_COPY: y = a;
         OP_SEL:  y = (a != '0) ? b : prev;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/valu_reduce.sv
module valu_reduce
   import tile_valu_pkg::*;
#(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int W    = 32
) (
   input  red_kind_e                kind,
   input  logic [ROWS*COLS*W-1:0]   tile,
   output logic [ROWS*COLS*W-1:0]   row_bc,
   output logic [ROWS*COLS*W-1:0]   col_bc,
   output logic [ROWS*COLS*W-1:0]   all_bc
);
   logic [W-1:0] row_val [ROWS];
   logic [W-1:0] col_val [COLS];
   logic [W-1:0] tile_val;

   function automatic logic [W-1:0] combine(input red_kind_e k,
                                            input logic [W-1:0] x,
                                            input logic [W-1:0] z);
      logic signed [W-1:0] sx, sz;
      sx = x;
      sz = z;
      unique case (k)
         RK_SUM:  return x + z;
         RK_MAX:  return (sx < sz) ? z : x;
         RK_MIN:  return (sx < sz) ? x : z;
         default: return x * z;
      endcase
   endfunction

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_comb begin
         row_val[r] = tile[(r*COLS)*W +: W];
         for (int c = 1; c < COLS; c++)
            row_val[r] = combine(kind, row_val[r], tile[(r*COLS+c)*W +: W]);
      end
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      always_comb begin
         col_val[c] = tile[c*W +: W];
         for (int r = 1; r < ROWS; r++)
            col_val[c] = combine(kind, col_val[c], tile[(r*COLS+c)*W +: W]);
      end
   end

   // whole tile folds the per-row values; wrap arithmetic keeps this order-free
   always_comb begin
      tile_val = row_val[0];
      for (int r = 1; r < ROWS; r++)
         tile_val = combine(kind, tile_val, row_val[r]);
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_bc_r
      for (genvar c = 0; c < COLS; c++) begin : g_bc_c
         assign row_bc[(r*COLS+c)*W +: W] = row_val[r];
         assign col_bc[(r*COLS+c)*W +: W] = col_val[c];
         assign all_bc[(r*COLS+c)*W +: W] = tile_val;
      end
   end
endmodule

// File: rtl/tile_valu.sv
module tile_valu
   import tile_valu_pkg::*;
#(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int W    = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [4:0]              in_op,
   input  logic [ROWS*COLS*W-1:0]  in_a,
   input  logic [ROWS*COLS*W-1:0]  in_b,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [ROWS*COLS*W-1:0]  out_data
);
   localparam int N      = ROWS * COLS;
   localparam int TILE_W = N * W;

   initial begin
      assert (W >= 8 && (W & (W - 1)) == 0)
         else $error("tile_valu: W must be a power of two of at least 8");
      assert (ROWS >= 1 && COLS >= 1)
         else $error("tile_valu: tile needs at least one row and column");
      assert (N <= 256)
         else $error("tile_valu: tile larger than supported");
   end

   logic                accept;
   logic [TILE_W-1:0]   result_q;
   logic [TILE_W-1:0]   next_tile;
   logic [TILE_W-1:0]   lane_tile, row_bc, col_bc, all_bc;
   logic [OP_W-1:0]     op_plus2;
   red_kind_e           kind;
   op_group_e           grp;
   logic                op_valid_code;

   assign in_ready  = !out_valid;
   assign accept    = in_valid && in_ready;
   assign op_plus2  = in_op + 5'd2;
   assign kind      = red_kind_e'(op_plus2[1:0]);
   assign op_valid_code = (in_op <= OP_LAST);

   always_comb begin
      if (in_op >= OP_TILE0)      grp = GRP_TILE;
      else if (in_op >= OP_COL0)  grp = GRP_COL;
      else if (in_op >= OP_ROW0)  grp = GRP_ROW;
      else                        grp = GRP_LANE;
   end

   for (genvar i = 0; i < N; i++) begin : g_lane
      valu_lane #(.W(W)) u_lane (
         .op   (in_op),
         .a    (in_a[i*W +: W]),
         .b    (in_b[i*W +: W]),
         .prev (result_q[i*W +: W]),
         .y    (lane_tile[i*W +: W])
      );
   end

   valu_reduce #(.ROWS(ROWS), .COLS(COLS), .W(W)) u_reduce (
      .kind   (kind),
      .tile   (in_a),
      .row_bc (row_bc),
      .col_bc (col_bc),
      .all_bc (all_bc)
   );

   always_comb begin
      if (!op_valid_code)
         next_tile = '0;
      else begin
         unique case (grp)
            GRP_ROW:  next_tile = row_bc;
            GRP_COL:  next_tile = col_bc;
            GRP_TILE: next_tile = all_bc;
            default:  next_tile = lane_tile;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result_q  <= '0;
      end else begin
         if (accept) begin
            out_valid <= 1'b1;
            result_q  <= next_tile;
         end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   assign out_data = result_q;

   // R2
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R2
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R2
   retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> !out_valid);

   for (genvar i = 0; i < N; i++) begin : g_chk
      // R6
      cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && (in_op == OP_LT || in_op == OP_NE || in_op == OP_EQ))
            |=> (out_data[i*W+1 +: W-1] == '0));
      // R7
      relu_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && in_op == OP_RELU) |=> !out_data[i*W+W-1]);
      // R11
      tile_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && in_op >= OP_TILE0 && in_op <= OP_LAST)
            |=> (out_data[i*W +: W] == out_data[W-1:0]));
      // R9
      row_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && in_op >= OP_ROW0 && in_op < OP_COL0)
            |=> (out_data[i*W +: W] == out_data[(i/COLS)*COLS*W +: W]));
      // R10
      col_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && in_op >= OP_COL0 && in_op < OP_TILE0)
            |=> (out_data[i*W +: W] == out_data[(i%COLS)*W +: W]));
   end
endmodule

// File: tb/tile_valu_test.sv
module tile_valu_test;
   localparam int ROWS = 4;
   localparam int COLS = 4;
   localparam int W    = 32;
   localparam int N    = ROWS * COLS;
   localparam int TW   = N * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [4:0]    in_op = '0;
   logic [TW-1:0] in_a = '0, in_b = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [TW-1:0] out_data;

   int vectors = 0;
   int misses  = 0;

   always #2.5 clk = ~clk;

   tile_valu #(.ROWS(ROWS), .COLS(COLS), .W(W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   // model state
   bit            m_valid = 0;
   logic [TW-1:0] m_reg   = '0;
   int            m_op    = 0;
   bit            first_chk = 1;
   int unsigned   seed = 32'h1234_5678;

   function automatic string req_of(int op);
      if (op <= 3)  return "R3";
      if (op == 6 || op == 7) return "R5";
      if (op <= 10 || op == 15 || op == 16) return "R4";
      if (op <= 13) return "R6";
      if (op == 14) return "R7";
      if (op == 17) return "R8";
      if (op <= 21) return "R9";
      if (op <= 25) return "R10";
      if (op <= 29) return "R11";
      return "R12";
   endfunction

   function automatic int fold(int k, int x, int z);
      case (k)
         0: return x + z;
         1: return (x > z) ? x : z;
         2: return (x < z) ? x : z;
         default: return x * z;
      endcase
   endfunction

   function automatic logic [TW-1:0] model(int op, logic [TW-1:0] a, logic [TW-1:0] b,
                                          logic [TW-1:0] prev);
      logic [TW-1:0] t;
      int x, z, acc;
      t = '0;
      if (op >= 18 && op <= 29) begin
         int k;
         k = (op - 18) % 4;
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
               if (op < 22) begin
                  acc = a[(r*COLS)*W +: W];
                  for (int j = 1; j < COLS; j++) acc = fold(k, acc, a[(r*COLS+j)*W +: W]);
               end else if (op < 26) begin
                  acc = a[c*W +: W];
                  for (int j = 1; j < ROWS; j++) acc = fold(k, acc, a[(j*COLS+c)*W +: W]);
               end else begin
                  acc = a[W-1:0];
                  for (int j = 1; j < N; j++) acc = fold(k, acc, a[j*W +: W]);
               end
               t[(r*COLS+c)*W +: W] = acc;
            end
         return t;
      end
      for (int i = 0; i < N; i++) begin
         x = a[i*W +: W];
         z = b[i*W +: W];
         case (op)
            0: acc = x + z;
            1: acc = x - z;
            2: acc = x * z;
            3: acc = (z == 0) ? 0 : ((x == 32'sh8000_0000 && z == -1) ? x : x / z);
            4: acc = (x > z) ? x : z;
            5: acc = (x < z) ? x : z;
            6: acc = x << (z & 31);
            7: acc = x >>> (z & 31);
            8: acc = x & z;
            9: acc = x | z;
            10: acc = x ^ z;
            11: acc = (x < z) ? 1 : 0;
            12: acc = (x != z) ? 1 : 0;
            13: acc = (x == z) ? 1 : 0;
            14: acc = (x > 0) ? x : 0;
            15: acc = ~x;
            16: acc = x;
            17: acc = (x != 0) ? z : int'(prev[i*W +: W]);
            default: acc = 0;
         endcase
         t[i*W +: W] = acc;
      end
      return t;
   endfunction

   function automatic int unsigned nxt();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   function automatic logic [W-1:0] corner(int i);
      case (i % 8)
         0: return 32'd0;
         1: return 32'd1;
         2: return 32'hFFFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'h7FFF_FFFF;
         5: return 32'd7;
         6: return -32'sd7;
         default: return 32'd37;
      endcase
   endfunction

   task automatic make_tiles(int pat, output logic [TW-1:0] a, output logic [TW-1:0] b);
      for (int i = 0; i < N; i++) begin
         case (pat)
            0: begin a[i*W +: W] = nxt(); b[i*W +: W] = nxt(); end
            1: begin a[i*W +: W] = W'(int'(nxt() % 16) - 8); b[i*W +: W] = W'(int'(nxt() % 16) - 8); end
            2: begin a[i*W +: W] = corner(i); b[i*W +: W] = corner(i * 3 + 2); end
            3: begin a[i*W +: W] = nxt(); b[i*W +: W] = 32'(i * 9); end
            4: begin a[i*W +: W] = 32'h8000_0000; b[i*W +: W] = corner(i % 3); end
            default: begin a[i*W +: W] = (i % 3 == 0) ? 32'd0 : nxt(); b[i*W +: W] = nxt(); end
         endcase
      end
   endtask

   // at a falling edge: check current outputs, drive inputs, advance the model
   task automatic cycle(bit v, int op, logic [TW-1:0] a, logic [TW-1:0] b, bit rdy);
      string tag;
      tag = first_chk ? "R1" : "R2";
      vectors++;
      if (out_valid !== m_valid) begin
         misses++;
         $display("FAIL %s out_valid actual=%b expected=%b", tag, out_valid, m_valid);
      end
      if (in_ready !== !m_valid) begin
         misses++;
         $display("FAIL %s in_ready actual=%b expected=%b", tag, in_ready, !m_valid);
      end
      if (m_valid && out_data !== m_reg) begin
         misses++;
         $display("FAIL %s op=%0d out_data actual=%h expected=%h", req_of(m_op), m_op, out_data, m_reg);
      end
      first_chk = 0;
      in_valid  = v;
      in_op     = 5'(op);
      in_a      = a;
      in_b      = b;
      out_ready = rdy;
      if (v && !m_valid) begin
         m_reg   = model(op, a, b, m_reg);
         m_valid = 1;
         m_op    = op;
      end else if (m_valid && rdy) begin
         m_valid = 0;
      end
      @(negedge clk);
   endtask

   // request, stall with a competing request held up (R2), then retire
   task automatic xact(int op, logic [TW-1:0] a, logic [TW-1:0] b, int stall);
      logic [TW-1:0] ja, jb;
      cycle(1, op, a, b, 0);
      for (int s = 0; s < stall; s++) begin
         make_tiles(0, ja, jb);
         cycle(1, (op + 1) % 32, ja, jb, 0);
      end
      cycle(0, 0, '0, '0, 1);
   endtask

   initial begin
      #(100000 * 5);
      misses++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      logic [TW-1:0] a, b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset outputs, then SELECT with all-zero mask reads zero register
      cycle(0, 0, '0, '0, 0);
      make_tiles(0, a, b);
      xact(17, '0, b, 0);
      // every code over several patterns; R12 for 30 and 31
      for (int op = 0; op < 32; op++)
         for (int p = 0; p < 6; p++) begin
            make_tiles(p, a, b);
            xact(op, a, b, p % 3);
         end
      // R8: select chains following assorted producers
      for (int k = 0; k < 20; k++) begin
         make_tiles(k % 6, a, b);
         xact(k % 30, a, b, 0);
         make_tiles(5, a, b);
         xact(17, a, b, 1);
      end
      // R2: back-to-back with ready held high
      for (int k = 0; k < 10; k++) begin
         make_tiles(1, a, b);
         cycle(1, k, a, b, 1);
      end
      cycle(0, 0, '0, '0, 1);
      cycle(0, 0, '0, '0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule